// File: doc/BRIEF.md
# Parallel Input Receive FIFO

This block buffers 32-bit words arriving from a parallel digital input port. A word offered on the receive input is stored only while reception is enabled. Software drains the buffer one word at a time by reading a data register, and watches its fill state through a status word whose four level flags are all reported in inverted ("not") form. The fill count and the capacity can be read directly.

Two thresholds share one register and set where the almost-empty and almost-full flags switch. Two sticky error flags record a word lost to a full buffer and a read attempted on an empty one. Writing a one to either flag clears it. A control register enables reception, empties the buffer in one cycle, or restores the whole block to its reset state. After a whole-block reset, the block holds off all buffer traffic for a settle interval.

The register port takes one access per cycle. Read data is registered and appears on `reg_rdata` in the cycle after the access. Register byte offsets: control 0x00, status 0x04, thresholds 0x08, data 0x0C, capacity 0x10, fill level 0x14. Reads of any other offset return zero.

Top module: `par_rx_fifo`

## Requirements
- R1: After reset the fill level reads 0, the threshold register reads 0x00200020 (both thresholds 32), the control register reads 0, and status bits 23 and 22 are 0.
- R2: A word offered on `rx_valid` is stored only when control bit 5 (receive enable) is 1. Otherwise it is ignored and the fill level is unchanged.
- R3: A read of offset 0x0C removes the oldest stored word and returns it on `reg_rdata` one cycle after the access. Words leave in arrival order.
- R4: Status bits 15..12 are, from high to low: not-full, not-almost-full, not-almost-empty and not-empty. Each reads 1 when its condition is false.
- R5: Threshold register bits 15:0 hold the almost-empty count and bits 23:16 hold the almost-full count. Almost-empty holds while fill ≤ the almost-empty count. Almost-full holds while fill ≥ DEPTH − the almost-full count.
- R6: A word offered while the buffer is full is dropped, even if a pop happens in the same cycle. The drop sets status bit 23 (overrun), which stays set until cleared.
- R7: A data read while the buffer is empty leaves the fill level at 0 and returns the last word that was successfully read. It also sets status bit 22 (underrun), which stays set until cleared.
- R8: Writing the status register clears bit 23 and/or bit 22 wherever the written value has a 1. Bits written as 0 leave their flag unchanged.
- R9: Writing control bit 2 empties the buffer in one cycle. The threshold register and the receive enable take the written or held values; they are not reset.
- R10: Writing control bit 0 returns every register to its reset value. For the next SETTLE cycles, offered words are ignored, and data reads neither remove words nor set underrun.
- R11: Offset 0x14 returns the fill count and offset 0x10 returns DEPTH (1024 by default), each in bits 19:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive word offered this cycle |
| rx_data | input | 32 | Received word |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |

## Verification
A table of cumulative push and pop bursts walks the fill level through empty, one word, the almost-empty edge (32 and 33), the almost-full edge (992 and 991), full, and back again. This separates an off-by-one at each threshold comparison from an error in the inversion of the flags. Each pop in these bursts also checks arrival order across pointer wrap. Directed tests then push into a full buffer and pop from an empty one, clear the two sticky flags one at a time, offer words with reception disabled, reprogram the thresholds to small values, and offer traffic inside and after the settle window. These tests tell a dropped or repeated word apart from a flag that is simply mis-reported.

// File: rtl/par_rx_pkg.sv
package par_rx_pkg;

    localparam int DW = 32;

    // register byte offsets
    localparam logic [4:0] OFF_CTRL  = 5'h00;
    localparam logic [4:0] OFF_STAT  = 5'h04;
    localparam logic [4:0] OFF_THR   = 5'h08;
    localparam logic [4:0] OFF_DATA  = 5'h0C;
    localparam logic [4:0] OFF_SIZE  = 5'h10;
    localparam logic [4:0] OFF_LEVEL = 5'h14;

    // control bits
    localparam int CB_BLK_RST  = 0;
    localparam int CB_FIFO_CLR = 2;
    localparam int CB_RX_EN    = 5;

    // status bits
    localparam int SB_NEMPTY = 12;
    localparam int SB_UDR    = 22;
    localparam int SB_OVR    = 23;

    typedef struct packed {
        logic nfull;
        logic nafull;
        logic naempty;
        logic nempty;
    } nflags_t;

endpackage

// File: rtl/rx_store.sv
module rx_store #(
    parameter int DEPTH = 1024,
    parameter int DW    = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [DW-1:0]    data_i,
    input  logic             pop_i,
    output logic [DW-1:0]    head_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             empty_o,
    output logic             ovr_evt_o,
    output logic             udr_evt_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic full, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full      = (st_q.cnt == CNT_W'(DEPTH));
        empty_o   = (st_q.cnt == '0);
        push_ok   = push_i && !full && !clr_i;
        pop_ok    = pop_i && !empty_o && !clr_i;
        ovr_evt_o = push_i && full && !clr_i;
        udr_evt_o = pop_i && empty_o && !clr_i;
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = wrap_inc(st_q.wr);
            if (pop_ok)  st_d.rd = wrap_inc(st_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= data_i;
    end

    assign head_o = mem[st_q.rd];
    assign cnt_o  = st_q.cnt;

    // R11: fill count never exceeds capacity
    p_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    // R6: full buffer with no pop keeps its count when offered a word
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i && !clr_i) |=> (cnt_o == CNT_W'(DEPTH)));
    // R9: clear empties in one cycle
    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
    // R3: no traffic, no count change
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i && !clr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/rx_flags.sv
module rx_flags #(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic [15:0]               ae_thr_i,
    input  logic [7:0]                af_thr_i,
    output par_rx_pkg::nflags_t       nf_o
);

    logic [31:0] cnt32, af_lim;

    always_comb begin
        cnt32  = 32'(cnt_i);
        af_lim = (32'(af_thr_i) >= 32'(DEPTH)) ? 32'd0 : 32'(DEPTH) - 32'(af_thr_i);
        nf_o.nempty  = (cnt32 != 32'd0);
        nf_o.naempty = !(cnt32 <= 32'(ae_thr_i));
        nf_o.nafull  = !(cnt32 >= af_lim);
        nf_o.nfull   = (cnt32 != 32'(DEPTH));
    end

endmodule

// File: rtl/par_rx_fifo.sv
module par_rx_fifo #(
    parameter int DEPTH   = 1024,
    parameter int AE_INIT = 32,
    parameter int AF_INIT = 32,
    parameter int SETTLE  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [31:0] rx_data,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    import par_rx_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SET_W = $clog2(SETTLE + 1);
    localparam logic [19:0] SIZE20 = 20'(DEPTH);

    typedef struct packed {
        logic             en;
        logic [15:0]      ae_thr;
        logic [7:0]       af_thr;
        logic             ovr;
        logic             udr;
        logic [DW-1:0]    last;
        logic [DW-1:0]    rdata;
        logic [SET_W-1:0] settle;
    } regs_t;

    localparam regs_t REGS_RST = '{
        en: 1'b0, ae_thr: 16'(AE_INIT), af_thr: 8'(AF_INIT),
        ovr: 1'b0, udr: 1'b0, last: '0, rdata: '0, settle: '0};

    regs_t r_d, r_q;

    logic rd_hit, wr_hit, settling, blk_rst, fifo_clr, push, pop;
    logic empty, ovr_evt, udr_evt;
    logic [DW-1:0] head;
    logic [CNT_W-1:0] level;
    nflags_t nf;
    logic [31:0] stat_word;

    rx_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr), .push_i(push),
        .data_i(rx_data), .pop_i(pop), .head_o(head), .cnt_o(level),
        .empty_o(empty), .ovr_evt_o(ovr_evt), .udr_evt_o(udr_evt));

    rx_flags #(.DEPTH(DEPTH)) i_flags (
        .cnt_i(level), .ae_thr_i(r_q.ae_thr), .af_thr_i(r_q.af_thr), .nf_o(nf));

    always_comb begin
        rd_hit   = reg_en && !reg_we;
        wr_hit   = reg_en && reg_we;
        settling = (r_q.settle != '0);
        blk_rst  = wr_hit && (reg_addr == OFF_CTRL) && reg_wdata[CB_BLK_RST];
        fifo_clr = blk_rst || (wr_hit && (reg_addr == OFF_CTRL) && reg_wdata[CB_FIFO_CLR]);
        push     = rx_valid && r_q.en && !settling;
        pop      = rd_hit && (reg_addr == OFF_DATA) && !settling;

        stat_word = '0;
        stat_word[SB_NEMPTY +: 4] = nf;
        stat_word[SB_UDR] = r_q.udr;
        stat_word[SB_OVR] = r_q.ovr;

        r_d = r_q;
        r_d.settle = settling ? r_q.settle - 1'b1 : '0;

        if (wr_hit) begin
            case (reg_addr)
                OFF_CTRL: r_d.en = reg_wdata[CB_RX_EN];
                OFF_THR: begin
                    r_d.ae_thr = reg_wdata[15:0];
                    r_d.af_thr = reg_wdata[23:16];
                end
                OFF_STAT: begin
                    if (reg_wdata[SB_OVR]) r_d.ovr = 1'b0;
                    if (reg_wdata[SB_UDR]) r_d.udr = 1'b0;
                end
                default: ;
            endcase
        end
        if (ovr_evt) r_d.ovr = 1'b1;
        if (udr_evt) r_d.udr = 1'b1;
        if (pop && !empty) r_d.last = head;

        if (rd_hit) begin
            case (reg_addr)
                OFF_CTRL:  r_d.rdata = {26'd0, r_q.en, 5'd0};
                OFF_STAT:  r_d.rdata = stat_word;
                OFF_THR:   r_d.rdata = {8'd0, r_q.af_thr, r_q.ae_thr};
                OFF_DATA:  r_d.rdata = (pop && !empty) ? head : r_q.last;
                OFF_SIZE:  r_d.rdata = {12'd0, SIZE20};
                OFF_LEVEL: r_d.rdata = {12'd0, 20'(level)};
                default:   r_d.rdata = '0;
            endcase
        end

        if (blk_rst) begin
            r_d = REGS_RST;
            r_d.settle = SET_W'(SETTLE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign reg_rdata = r_q.rdata;

    // R6: overrun stays set until a one is written to it or the block resets
    p_ovr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovr && !(wr_hit && reg_addr == OFF_STAT && reg_wdata[SB_OVR]) && !blk_rst)
        |=> r_q.ovr);
    // R7: underrun stays set likewise
    p_udr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.udr && !(wr_hit && reg_addr == OFF_STAT && reg_wdata[SB_UDR]) && !blk_rst)
        |=> r_q.udr);
    // R7: empty read returns the previously delivered word
    p_udr_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (reg_rdata == $past(r_q.last)));
    // R2: with receive off, the level never grows
    p_en_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.en && !pop) |=> (level <= $past(level)));
    // R10: no buffer traffic inside the settle window
    p_settle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        settling |=> $stable(level));

endmodule

// File: tb/test_par_rx_fifo.sv
module test_par_rx_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic reg_en = 1'b0;
    logic reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int unsigned wseq = 0;
    int unsigned rseq = 0;

    // rows: words pushed, words popped, expected level, expected status[15:12]
    localparam int VEC [8][4] = '{
        '{0,   0,   0,    'hC},
        '{1,   0,   1,    'hD},
        '{31,  0,   32,   'hD},
        '{1,   0,   33,   'hF},
        '{959, 0,   992,  'hB},
        '{0,   1,   991,  'hF},
        '{33,  0,   1024, 'h3},
        '{0,   992, 32,   'hD}
    };

    par_rx_fifo i_par_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word_of(int unsigned s);
        return 32'hA500_0000 + 32'(s);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic reg_wr(logic [4:0] a, logic [31:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic push_n(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data = word_of(wseq);
            wseq++;
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop_n(int n, string req);
        logic [31:0] d;
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            reg_rd(5'h0C, d);
            if (d !== word_of(rseq) && bad == 0) begin
                bad = 1;
                check(req, d, word_of(rseq));
            end
            rseq++;
        end
        if (bad == 0) check(req, 32'd0, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(5'h14, d); check("R1 level", d, 32'd0);
        reg_rd(5'h08, d); check("R1 thresholds", d, 32'h0020_0020);
        reg_rd(5'h00, d); check("R1 control", d, 32'd0);
        reg_rd(5'h04, d); check("R1 sticky flags", d & 32'h00C0_0000, 32'd0);
        // R11 capacity
        reg_rd(5'h10, d); check("R11 size", d, 32'(DEPTH));

        // R2 disabled push is ignored
        push_n(3); wseq -= 3;
        reg_rd(5'h14, d); check("R2 disabled push", d, 32'd0);

        reg_wr(5'h00, 32'h20);
        reg_rd(5'h00, d); check("R2 enable readback", d, 32'h20);

        // table walk: R3 order, R4/R5 flags, R11 level
        for (int v = 0; v < 8; v++) begin
            push_n(VEC[v][0]);
            if (VEC[v][1] > 0) pop_n(VEC[v][1], "R3 order");
            reg_rd(5'h14, d); check("R11 level", d, 32'(VEC[v][2]));
            reg_rd(5'h04, d); check("R4 R5 flags", (d >> 12) & 32'hF, 32'(VEC[v][3]));
        end

        // R6 overrun
        push_n(DEPTH - 32);
        push_n(1); wseq--;
        reg_rd(5'h14, d); check("R6 level after drop", d, 32'(DEPTH));
        reg_rd(5'h04, d); check("R6 overrun flag", (d >> 22) & 32'h3, 32'h2);
        pop_n(DEPTH, "R6 order after drop");

        // R7 underrun
        reg_rd(5'h0C, d); check("R7 repeat last", d, word_of(rseq - 1));
        reg_rd(5'h14, d); check("R7 level", d, 32'd0);
        reg_rd(5'h04, d); check("R7 underrun flag", (d >> 22) & 32'h3, 32'h3);

        // R8 write-one-to-clear
        reg_wr(5'h04, 32'h0080_0000);
        reg_rd(5'h04, d); check("R8 clear overrun only", (d >> 22) & 32'h3, 32'h1);
        reg_wr(5'h04, 32'h0040_0000);
        reg_rd(5'h04, d); check("R8 clear underrun", (d >> 22) & 32'h3, 32'h0);

        // R9 FIFO clear keeps thresholds and enable
        push_n(5); rseq += 5;
        reg_wr(5'h00, 32'h24);
        reg_rd(5'h14, d); check("R9 emptied", d, 32'd0);
        reg_rd(5'h08, d); check("R9 thresholds kept", d, 32'h0020_0020);
        push_n(1);
        pop_n(1, "R9 data after clear");

        // R5 small thresholds: ae=2, af=3 (almost-full at >= 1021)
        reg_wr(5'h08, 32'h0003_0002);
        reg_rd(5'h08, d); check("R5 readback", d, 32'h0003_0002);
        push_n(2);
        reg_rd(5'h04, d); check("R5 ae at count 2", (d >> 12) & 32'hF, 32'hD);
        push_n(1);
        reg_rd(5'h04, d); check("R5 not ae at count 3", (d >> 12) & 32'hF, 32'hF);
        push_n(1017);
        reg_rd(5'h04, d); check("R5 not af at 1020", (d >> 12) & 32'hF, 32'hF);
        push_n(1);
        reg_rd(5'h04, d); check("R5 af at 1021", (d >> 12) & 32'hF, 32'hB);

        // R10 block reset and settle window
        reg_wr(5'h00, 32'h1);
        reg_rd(5'h14, d); check("R10 level zero", d, 32'd0);
        reg_rd(5'h08, d); check("R10 thresholds restored", d, 32'h0020_0020);
        reg_wr(5'h00, 32'h20);
        push_n(1); wseq--;
        reg_rd(5'h0C, d);
        reg_rd(5'h14, d); check("R10 push ignored while settling", d, 32'd0);
        reg_rd(5'h04, d); check("R10 no underrun while settling", (d >> 22) & 32'h3, 32'h0);
        repeat (20) @(negedge clk);
        rseq = wseq;
        push_n(1);
        reg_rd(5'h14, d); check("R10 push after settle", d, 32'd1);
        pop_n(1, "R10 data after settle");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule